// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. Software programs it through a small register port: a 32-bit control word, a source pointer, a destination pointer and two transfer counts, one for each of two buffers. Each beat reads one item from the source pointer over a simple master port and writes the same item to the destination pointer. After the beat, each pointer advances by its own programmed step, and the count of the active buffer goes down by one.

When the count of the active buffer reaches zero, that buffer's completion flag is set and the channel switches to the other buffer, so the two buffers work as a ping-pong pair. In memory mode beats run back to back. In peripheral mode a ready line, picked from a 16-bit vector, paces each beat. After every beat in peripheral mode the channel can wait a programmed number of clocks before it looks at that ready line again.

An interrupt line is raised from the completion flags when enabled. A priority bit is exported for an arbiter outside the block.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads zero, and `irq` and `m_req` are low. In the control word at register address 0, the kept fields are: ready select [26:23], hold count [21:14], destination step [13:12], source step [11:10], priority 9, interrupt enable 6, pause 4, size [3:2], direction 1 and peripheral mode 0. Bits 31:27, 22, 8, 7 and 5 always read zero, so writing all ones reads back 0x07BFFE5F.
- R2: Each beat first reads at the source pointer (`m_we`=0) and then writes that same data to the destination pointer (`m_we`=1). `m_size` equals the size field. In memory mode (bit 0 = 0) the direction bit has no effect.
- R3: The step codes 00, 01, 10 and 11 advance a pointer by 0, 1, 2 and 4 after each beat. The source and destination use separate codes. The pointers read back at addresses 1 and 2.
- R4: Counts are written at address 3 (buffer A) and address 4 (buffer B). A nonzero count on the active buffer starts beats. When that count reaches zero, the buffer's flag is set and the other buffer becomes active. The status word at address 5 reads {flag B, flag A, active buffer} in bits [2:0], with 1 meaning B is active.
- R5: In peripheral mode (bit 0 = 1) a beat starts only while `rdy_vec[ready select]` is high. Other bits of `rdy_vec` have no effect.
- R6: In peripheral mode, after a write is acknowledged, `m_req` stays low for hold count + 1 cycles before the next read. In memory mode this gap is always 1 cycle.
- R7: While pause is set, no new beat starts.
- R8: `irq` is high exactly when interrupt enable is set and at least one flag is set. Writing 1 to control bit 7 clears flag A, and writing 1 to bit 8 clears flag B. `irq` stays high while the other flag is still set.
- R9: Writing 1 to control bit 5 stops the channel, clears both flags and both counts, and makes A the active buffer. It leaves the configuration fields unchanged.
- R10: Size code 11 keeps the channel idle, and it makes no bus access.
- R11: `hi_prio` follows control bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rdy_vec | input | 16 | Peripheral ready lines |
| m_req | output | 1 | Master access request, held until acknowledged |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | ADDR_W | Master address |
| m_size | output | 2 | Access size code |
| m_wdata | output | DATA_W | Master write data |
| m_rdata | input | DATA_W | Master read data, taken with `m_ack` |
| m_ack | input | 1 | Master access acknowledge |
| hi_prio | output | 1 | Priority flag for an external arbiter |
| irq | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. Readback, `irq` and `hi_prio` are therefore checked half a cycle after that edge. Each access is held until acknowledged, and the bus model answers one cycle after it sees a request. Written items are popped from the expected queue at the falling edge where they are acknowledged, so the order of beats is checked as well as their content. The idle gap before each read is counted in falling edges, which gives hold count + 1 in peripheral mode and 1 in memory mode. Flag, pointer and count readback happen only after the expected queue has drained and a few cycles have passed.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_HOLD} chan_st_e;

  typedef struct packed {
    logic [3:0] rdy_sel;
    logic [7:0] hold;
    logic [1:0] dinc;
    logic [1:0] sinc;
    logic       hi_prio;
    logic       irq_en;
    logic       pause;
    logic [1:0] size;
    logic       dir;
    logic       periph;
  } chan_cfg_t;

  localparam int RA_W = 3;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_SRC  = 3'd1;
  localparam logic [RA_W-1:0] RA_DST  = 3'd2;
  localparam logic [RA_W-1:0] RA_CNTA = 3'd3;
  localparam logic [RA_W-1:0] RA_CNTB = 3'd4;
  localparam logic [RA_W-1:0] RA_STAT = 3'd5;

  localparam int B_CLRB = 8;
  localparam int B_CLRA = 7;
  localparam int B_CRST = 5;

  localparam logic [1:0] SIZE_BAD = 2'b11;

  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              beat_done,
  output chan_cfg_t         cfg,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              cnt_nz,
  output logic [1:0]        flags,
  output logic              chan_rst
);

  chan_cfg_t               cfg_q, cfg_d;
  logic [ADDR_W-1:0]       src_q, src_d, dst_q, dst_d;
  logic [1:0][CNT_W-1:0]   cnt_q, cnt_d;
  logic [1:0]              flag_q, flag_d;
  logic                    buf_q, buf_d;
  logic                    wr_ctrl, clr_a, clr_b, last_beat;
  logic                    unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_ctrl  = wr_en && (addr == RA_CTRL);
  assign chan_rst = wr_ctrl && wdata[B_CRST];
  assign clr_a    = wr_ctrl && wdata[B_CLRA];
  assign clr_b    = wr_ctrl && wdata[B_CLRB];
  assign last_beat = beat_done && (cnt_q[buf_q] == CNT_W'(1));

  always_comb begin
    cfg_d  = cfg_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    buf_d  = buf_q;
    if (beat_done) begin
      src_d = src_q + ADDR_W'(step_bytes(cfg_q.sinc));
      dst_d = dst_q + ADDR_W'(step_bytes(cfg_q.dinc));
      cnt_d[buf_q] = cnt_q[buf_q] - CNT_W'(1);
    end
    if (clr_a) flag_d[0] = 1'b0;
    if (clr_b) flag_d[1] = 1'b0;
    if (last_beat) begin
      flag_d[buf_q] = 1'b1;
      buf_d = ~buf_q;
    end
    if (wr_en) begin
      case (addr)
        RA_CTRL: begin
          cfg_d.rdy_sel = wdata[26:23];
          cfg_d.hold    = wdata[21:14];
          cfg_d.dinc    = wdata[13:12];
          cfg_d.sinc    = wdata[11:10];
          cfg_d.hi_prio = wdata[9];
          cfg_d.irq_en  = wdata[6];
          cfg_d.pause   = wdata[4];
          cfg_d.size    = wdata[3:2];
          cfg_d.dir     = wdata[1];
          cfg_d.periph  = wdata[0];
        end
        RA_SRC:  src_d    = wdata[ADDR_W-1:0];
        RA_DST:  dst_d    = wdata[ADDR_W-1:0];
        RA_CNTA: cnt_d[0] = wdata[CNT_W-1:0];
        RA_CNTB: cnt_d[1] = wdata[CNT_W-1:0];
        default: ;
      endcase
    end
    if (chan_rst) begin
      cnt_d  = '0;
      flag_d = '0;
      buf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      flag_q <= '0;
      buf_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      buf_q  <= buf_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[26:23] = cfg_q.rdy_sel;
        rdata[21:14] = cfg_q.hold;
        rdata[13:12] = cfg_q.dinc;
        rdata[11:10] = cfg_q.sinc;
        rdata[9]     = cfg_q.hi_prio;
        rdata[6]     = cfg_q.irq_en;
        rdata[4]     = cfg_q.pause;
        rdata[3:2]   = cfg_q.size;
        rdata[1]     = cfg_q.dir;
        rdata[0]     = cfg_q.periph;
      end
      RA_SRC:  rdata = 32'(src_q);
      RA_DST:  rdata = 32'(dst_q);
      RA_CNTA: rdata = 32'(cnt_q[0]);
      RA_CNTB: rdata = 32'(cnt_q[1]);
      RA_STAT: rdata[2:0] = {flag_q, buf_q};
      default: ;
    endcase
  end

  assign cfg    = cfg_q;
  assign src    = src_q;
  assign dst    = dst_q;
  assign cnt_nz = |cnt_q[buf_q];
  assign flags  = flag_q;

  // R4: a flag only rises after the final beat of its own buffer
  a_r4_flag_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(beat_done && !buf_q));
  a_r4_flag_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(beat_done && buf_q));
  // R9: channel reset empties both counts and flags
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (cnt_q == '0) && (flag_q == 2'b00) && !buf_q);

endmodule

// File: rtl/dma_chan_holdoff.sv
`timescale 1ns/1ps
module dma_chan_holdoff #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_val,
  input  logic              run,
  input  logic              clr,
  output logic              done
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (load)
      cnt_d = wait_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == WAIT_W'(1));

endmodule

// File: rtl/dma_chan_fsm.sv
`timescale 1ns/1ps
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8,
  parameter int NRDY   = 16,
  localparam int SEL_W = $clog2(NRDY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph,
  input  logic              pause,
  input  logic [1:0]        size,
  input  logic [SEL_W-1:0]  rdy_sel,
  input  logic [WAIT_W-1:0] hold,
  input  logic [NRDY-1:0]   rdy_vec,
  input  logic              cnt_nz,
  input  logic              chan_rst,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              m_ack,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic              beat_done
);

  chan_st_e          st_q, st_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              go, hold_load, hold_done, rdy_sel_bit;

  assign rdy_sel_bit = rdy_vec[rdy_sel];
  assign go = cnt_nz && !pause && (size != SIZE_BAD) && (!periph || rdy_sel_bit);
  assign beat_done = (st_q == ST_WR) && m_ack && !chan_rst;
  assign hold_load = beat_done && periph && (hold != '0);

  dma_chan_holdoff #(.WAIT_W(WAIT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hold_load),
    .wait_val (hold),
    .run      (st_q == ST_HOLD),
    .clr      (chan_rst),
    .done     (hold_done)
  );

  always_comb begin
    st_d  = st_q;
    dat_d = dat_q;
    case (st_q)
      ST_IDLE: if (go) st_d = ST_RD;
      ST_RD: if (m_ack) begin
        dat_d = m_rdata;
        st_d  = ST_WR;
      end
      ST_WR: if (m_ack) st_d = hold_load ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (hold_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (chan_rst) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      dat_q <= dat_d;
    end
  end

  assign m_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_we    = (st_q == ST_WR);
  assign m_addr  = (st_q == ST_WR) ? dst : src;
  assign m_wdata = dat_q;

  // R2: a request is held, same kind, until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !chan_rst) |=> (m_req && $stable(m_we)));
  // R5: no beat starts while the selected ready line is low
  a_r5_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && periph && !rdy_sel_bit) |=> !m_req);
  // R6: the holdoff state persists until its counter expires
  a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !hold_done && !chan_rst) |=> (st_q == ST_HOLD));
  // R7: pause blocks new beats
  a_r7_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pause) |=> !m_req);
  // R10: reserved size keeps the channel idle
  a_r10_bad_size_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && size == SIZE_BAD) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [15:0]       rdy_vec,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack,
  output logic              hi_prio,
  output logic              irq
);

  localparam int NRDY   = 16;
  localparam int WAIT_W = 8;

  logic              rst_meta_q, rst_sync_q;
  chan_cfg_t         cfg;
  logic [ADDR_W-1:0] src, dst;
  logic              cnt_nz, chan_rst, beat_done;
  logic [1:0]        flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .beat_done (beat_done),
    .cfg       (cfg),
    .src       (src),
    .dst       (dst),
    .cnt_nz    (cnt_nz),
    .flags     (flags),
    .chan_rst  (chan_rst)
  );

  dma_chan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .NRDY(NRDY)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .periph    (cfg.periph),
    .pause     (cfg.pause),
    .size      (cfg.size),
    .rdy_sel   (cfg.rdy_sel),
    .hold      (cfg.hold),
    .rdy_vec   (rdy_vec),
    .cnt_nz    (cnt_nz),
    .chan_rst  (chan_rst),
    .src       (src),
    .dst       (dst),
    .m_ack     (m_ack),
    .m_rdata   (m_rdata),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .beat_done (beat_done)
  );

  assign m_size  = cfg.size;
  assign hi_prio = cfg.hi_prio;
  assign irq     = cfg.irq_en && (|flags);

  // R8: the interrupt falls only through a clear, a channel reset or disabling
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(irq) |-> $past(reg_wr && reg_addr == RA_CTRL));

endmodule

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
  } wr_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] rdy_vec = '0;
  logic        m_req, m_we, m_ack = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic [1:0]  m_size;
  logic        hi_prio, irq;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int gap = 0;
  int last_gap = 0;
  bit counting = 0;
  wr_item_t exp_q[$];

  always #2.5 clk = ~clk;

  dma_chan u_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rdy_vec(rdy_vec),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .hi_prio(hi_prio), .irq(irq)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction

  function automatic logic [31:0] mk(input int sel, input int hold, input int dinc,
      input int sinc, input int hp, input int clrb, input int clra, input int ie,
      input int rs, input int pz, input int sz, input int dir, input int per);
    return (32'(sel) << 23) | (32'(hold) << 14) | (32'(dinc) << 12) | (32'(sinc) << 10)
         | (32'(hp) << 9) | (32'(clrb) << 8) | (32'(clra) << 7) | (32'(ie) << 6)
         | (32'(rs) << 5) | (32'(pz) << 4) | (32'(sz) << 2) | (32'(dir) << 1) | 32'(per);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic push_beats(input logic [31:0] s, input logic [31:0] d, input int n,
                            input int ss, input int ds, input logic [1:0] sz);
    for (int i = 0; i < n; i++)
      exp_q.push_back('{size: sz, addr: d + 32'(i * ds), data: mem_val(s + 32'(i * ss))});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // bus model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (m_req && !m_ack) begin
        m_ack = 1'b1;
        if (m_we) begin
          wr_item_t e;
          wr_cnt++;
          counting = 1; gap = 0;
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected write actual=0x%08h expected=none", m_addr);
          end else begin
            e = exp_q.pop_front();
            if (m_addr !== e.addr || m_wdata !== e.data || m_size !== e.size) begin
              fails++;
              $display("FAIL R2/R3 write actual=%h/%h/%0d expected=%h/%h/%0d",
                       m_addr, m_wdata, m_size, e.addr, e.data, e.size);
            end
          end
        end else begin
          rd_cnt++;
          m_rdata = mem_val(m_addr);
          if (counting) begin last_gap = gap; counting = 0; end
        end
      end else begin
        m_ack = 1'b0;
        if (counting && !m_req) gap++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset m_req", 32'(m_req), 0);

    // R1 reserved/self-clearing bits, R11 priority
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R1 ctrl readback", v, 32'h07BF_FE5F);
    chk("R11 hi_prio set", 32'(hi_prio), 1);
    wr(3'd0, 32'h0);
    chk("R11 hi_prio clear", 32'(hi_prio), 0);

    // R2 R3 R4 memory mode, direction bit set but ignored
    c = mk(0, 0, 3, 3, 0, 0, 0, 1, 0, 0, 2, 1, 0);
    wr(3'd0, c); wr(3'd1, 32'h100); wr(3'd2, 32'h200);
    push_beats(32'h100, 32'h200, 3, 4, 4, 2'd2);
    wr(3'd3, 32'd3);
    drain();
    rd(3'd5, v); chk("R4 status after A", v, 32'h3);
    chk("R8 irq after A", 32'(irq), 1);
    rd(3'd1, v); chk("R3 src end", v, 32'h10C);
    rd(3'd2, v); chk("R3 dst end", v, 32'h20C);
    rd(3'd3, v); chk("R4 count A zero", v, 32'h0);

    // R8 clear A
    wr(3'd0, c | (32'd1 << 7));
    rd(3'd5, v); chk("R8 status after clear A", v, 32'h1);
    chk("R8 irq cleared", 32'(irq), 0);

    // R3 steps 1/2, buffer B, interrupt disabled
    c = mk(0, 0, 2, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    wr(3'd0, c); wr(3'd1, 32'h300); wr(3'd2, 32'h400);
    push_beats(32'h300, 32'h400, 4, 1, 2, 2'd1);
    wr(3'd4, 32'd4);
    drain();
    rd(3'd5, v); chk("R4 status after B", v, 32'h4);
    chk("R8 irq masked", 32'(irq), 0);
    c = mk(0, 0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    wr(3'd0, c);
    chk("R8 irq enabled", 32'(irq), 1);
    wr(3'd1, 32'h500); wr(3'd2, 32'h600);
    push_beats(32'h500, 32'h600, 2, 0, 4, 2'd0);
    wr(3'd3, 32'd2);
    drain();
    rd(3'd5, v); chk("R4 status both", v, 32'h7);
    wr(3'd0, c | (32'd1 << 7));
    chk("R8 irq held by B", 32'(irq), 1);
    wr(3'd0, c | (32'd1 << 8));
    chk("R8 irq released", 32'(irq), 0);

    // R7 pause, R4 ping-pong
    c = mk(0, 0, 3, 3, 0, 0, 0, 1, 0, 1, 2, 0, 0);
    wr(3'd0, c); wr(3'd1, 32'h700); wr(3'd2, 32'h800);
    wr(3'd4, 32'd2); wr(3'd3, 32'd2);
    n0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R7 no access while paused", 32'(rd_cnt - n0), 0);
    push_beats(32'h700, 32'h800, 4, 4, 4, 2'd2);
    wr(3'd0, c & ~32'h10);
    drain();
    rd(3'd5, v); chk("R4 ping-pong status", v, 32'h7);
    wr(3'd0, (c & ~32'h10) | 32'h180);

    // R5 peripheral pacing on ready line 5
    rdy_vec = 16'h0010;
    c = mk(5, 0, 3, 0, 0, 0, 0, 1, 0, 0, 2, 0, 1);
    wr(3'd0, c); wr(3'd1, 32'h900); wr(3'd2, 32'hA00);
    wr(3'd4, 32'd3);
    n0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R5 wrong ready line", 32'(rd_cnt - n0), 0);
    push_beats(32'h900, 32'hA00, 3, 0, 4, 2'd2);
    rdy_vec = 16'h0020;
    drain();
    chk("R6 gap hold 0", 32'(last_gap), 1);

    // R6 holdoff 6 in peripheral mode, ignored in memory mode
    c = mk(5, 6, 3, 3, 0, 0, 0, 1, 0, 0, 2, 0, 1);
    wr(3'd0, c); wr(3'd1, 32'hB00); wr(3'd2, 32'hC00);
    push_beats(32'hB00, 32'hC00, 3, 4, 4, 2'd2);
    wr(3'd3, 32'd3);
    drain();
    chk("R6 gap hold 6", 32'(last_gap), 7);
    c = mk(5, 6, 3, 3, 0, 0, 0, 1, 0, 0, 2, 0, 0);
    wr(3'd0, c); wr(3'd1, 32'hD00); wr(3'd2, 32'hE00);
    push_beats(32'hD00, 32'hE00, 2, 4, 4, 2'd2);
    wr(3'd4, 32'd2);
    drain();
    chk("R6 gap memory mode", 32'(last_gap), 1);

    // R10 reserved size
    c = mk(5, 6, 3, 3, 1, 0, 0, 1, 0, 0, 3, 0, 0);
    wr(3'd0, c);
    wr(3'd3, 32'd2);
    n0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no access", 32'(rd_cnt - n0), 0);
    chk("R8 irq before reset", 32'(irq), 1);

    // R9 channel reset
    wr(3'd0, c | (32'd1 << 5));
    rd(3'd0, v); chk("R9 config kept", v, c);
    rd(3'd5, v); chk("R9 status cleared", v, 32'h0);
    rd(3'd3, v); chk("R9 count A cleared", v, 32'h0);
    rd(3'd4, v); chk("R9 count B cleared", v, 32'h0);
    chk("R9 irq low", 32'(irq), 0);
    chk("R11 hi_prio kept", 32'(hi_prio), 1);
    chk("R2 all writes seen", 32'(exp_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule